// File: doc/BRIEF.md
# MSI-X Interrupt Vector Controller

This block turns per-vector interrupt requests from a device function into MSI-X messages. It keeps a vector table and a pending-bit array behind a 32-bit word port, and it holds the function-level enable and mask-all controls. Each vector has its own entry, which holds a 64-bit message address, 32-bit message data and a mask bit. A device-side "in use" flag gates each vector, so the function can leave some vectors unused.

A request on a vector that is in use either produces a message on a valid/ready output or, if the vector is masked, sets its pending bit. Each vector's effective mask is re-evaluated on every cycle. When a pending vector becomes unmasked, its pending bit moves into a dispatch set. If several vectors are released together, their messages leave one per cycle, lowest vector first.

Top module: `msix_vector_unit`

## Requirements
- R1: After reset the enable and mask-all controls are 0, every table word reads 0 except each vector-control word, which reads 1, and every pending word reads 0.
- R2: With regSel=0, register word 4*v+k addresses vector v: k=0 is address bits 31:0, k=1 is address bits 63:32, k=2 is message data, and k=3 is vector control with the mask in bit 0. Control bits 31:1 read as 0. Writes and reads are whole 32-bit words.
- R3: A vector is masked when enable is 0, when mask-all is 1, or when its own mask bit is 1.
- R4: A request on a masked vector that is in use sets its pending bit and sends no message.
- R5: A request on an unmasked vector that is in use gives msgValid=1 after the second rising edge following the request. The message carries that entry's address, data and vector number.
- R6: A request whose vector number is at or above NUM_VEC, or whose vector is not in use, changes nothing.
- R7: With regSel=1, bit b of word k holds the pending bit of vector 32*k+b. This is the same as byte v/8, bit v%8, little-endian. There are 2*ceil(NUM_VEC/64) words. Bits for absent vectors read 0. Writes to this region are ignored.
- R8: When a pending vector becomes unmasked, its pending bit clears and its message is sent.
- R9: Vectors released together are sent in ascending vector order, one message per cycle while msgReady is 1.
- R10: While msgValid=1 and msgReady=0, msgValid, msgVec, msgAddr and msgData hold their values.
- R11: Clearing a vector's "in use" flag also clears its pending bit and drops any message for it that has not yet been launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register word write strobe |
| regSel | input | 1 | 0 selects the vector table, 1 selects the pending array |
| regAddr | input | AW | Word index within the selected region |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regSel/regAddr (combinational) |
| ctlWrEn | input | 1 | Writes the enable and mask-all controls |
| ctlEnableIn | input | 1 | New enable value |
| ctlMaskAllIn | input | 1 | New mask-all value |
| useWrEn | input | 1 | Writes one vector's in-use flag |
| useSet | input | 1 | 1 marks the vector in use, 0 unmarks it |
| useVec | input | IW | Vector whose in-use flag is written |
| reqValid | input | 1 | Interrupt request strobe |
| reqVec | input | IW | Requested vector number |
| msgValid | output | 1 | A message is presented |
| msgReady | input | 1 | The sink accepts the message |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| msgVec | output | VW | Vector that produced the message |

## Verification
A corrupted pending or dispatch bit shows up within a cycle on the pending-array read path. It shows up two edges later as a message that should not exist, or as a message that is missing. A wrong mask bit shows up the same way: a request is either delivered or recorded when the other was due. The reference model is compared with the design on every clock, covering regRdata and the message outputs. A divergence is therefore reported in the cycle it first reaches a port, not only at the end of the scenario.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MAX_VW = 11;

  typedef struct packed {
    logic              tblWr;
    logic              launch;
    logic [MAX_VW-1:0] launchVec;
  } msix_strobe_t;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 12,
  parameter int VW = 4,
  parameter int AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  msix_strobe_t       strobe,
  input  logic               regSel,
  input  logic [AW-1:0]      regAddr,
  input  logic [31:0]        regWdata,
  input  logic [NUM_VEC-1:0] pendBits,
  output logic [NUM_VEC-1:0] vecMask,
  output logic [31:0]        regRdata,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData,
  output logic [VW-1:0]      msgVec
);
  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] dataW  [NUM_VEC];
  logic [VW-1:0] rowIdx;
  logic [VW-1:0] outIdx;

  assign rowIdx = regAddr[AW-1:2];
  assign outIdx = strobe.launchVec[VW-1:0];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrLo[v]  <= '0;
        addrHi[v]  <= '0;
        dataW[v]   <= '0;
        vecMask[v] <= 1'b1;
      end else if (strobe.tblWr && rowIdx == VW'(v)) begin
        case (regAddr[1:0])
          2'd0: addrLo[v] <= regWdata;
          2'd1: addrHi[v] <= regWdata;
          2'd2: dataW[v]  <= regWdata;
          default: vecMask[v] <= regWdata[0];
        endcase
      end
    end
  end

  always_comb begin
    int unsigned idx;
    regRdata = '0;
    if (regSel) begin
      for (int b = 0; b < 32; b++) begin
        idx = int'(regAddr) * 32 + b;
        if (idx < NUM_VEC) regRdata[b] = pendBits[idx];
      end
    end else if (int'(rowIdx) < NUM_VEC) begin
      case (regAddr[1:0])
        2'd0: regRdata = addrLo[rowIdx];
        2'd1: regRdata = addrHi[rowIdx];
        2'd2: regRdata = dataW[rowIdx];
        default: regRdata = {31'b0, vecMask[rowIdx]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
      msgVec  <= '0;
    end else if (strobe.launch) begin
      msgAddr <= {addrHi[outIdx], addrLo[outIdx]};
      msgData <= dataW[outIdx];
      msgVec  <= outIdx;
    end
  end

  AST_LAUNCH_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> (int'(strobe.launchVec) < NUM_VEC)); // R6
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 12,
  parameter int VW = 4,
  parameter int IW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrEn,
  input  logic               ctlEnableIn,
  input  logic               ctlMaskAllIn,
  input  logic               useWrEn,
  input  logic               useSet,
  input  logic [IW-1:0]      useVec,
  input  logic               reqValid,
  input  logic [IW-1:0]      reqVec,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [VW-1:0]      regRow,
  input  logic               msgReady,
  input  logic [NUM_VEC-1:0] vecMask,
  output msix_strobe_t       strobe,
  output logic [NUM_VEC-1:0] pendBits,
  output logic               msgValid
);
  logic enable, maskAll, funcMasked;
  logic [NUM_VEC-1:0] useBits, queued, effMask, hitVec, unuseVec, sentVec;
  logic [NUM_VEC-1:0] launchable, carry;
  logic [MAX_VW-1:0] pickIdx;
  logic anyLaunchable, launch;

  assign funcMasked    = !enable || maskAll;
  assign effMask       = vecMask | {NUM_VEC{funcMasked}};
  assign launchable    = queued & ~effMask;
  assign anyLaunchable = |launchable;
  assign launch        = anyLaunchable && (!msgValid || msgReady);

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (launchable[i]) pickIdx = MAX_VW'(i);
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign hitVec[v]   = reqValid && reqVec == IW'(v) && useBits[v];
    assign unuseVec[v] = useWrEn && !useSet && useVec == IW'(v);
    assign sentVec[v]  = launch && pickIdx == MAX_VW'(v);
    assign carry[v]    = pendBits[v] || hitVec[v] || (queued[v] && !sentVec[v]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      maskAll  <= 1'b0;
      useBits  <= '0;
      pendBits <= '0;
      queued   <= '0;
      msgValid <= 1'b0;
    end else begin
      if (ctlWrEn) begin
        enable  <= ctlEnableIn;
        maskAll <= ctlMaskAllIn;
      end
      for (int v = 0; v < NUM_VEC; v++)
        if (useWrEn && useVec == IW'(v)) useBits[v] <= useSet;
      pendBits <= effMask & carry & ~unuseVec;
      queued   <= ~effMask & carry & ~unuseVec;
      if (launch) msgValid <= 1'b1;
      else if (msgReady) msgValid <= 1'b0;
    end
  end

  assign strobe.tblWr     = regWrEn && !regSel && int'(regRow) < NUM_VEC;
  assign strobe.launch    = launch;
  assign strobe.launchVec = pickIdx;

  AST_PEND_ONLY_USED: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits & ~useBits) == '0); // R11
  AST_PEND_QUEUE_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits & queued) == '0); // R8
  AST_LAUNCH_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> msgValid); // R5
  AST_NO_LAUNCH_MASKED_FN: assert property (@(posedge clk) disable iff (!rstN)
    funcMasked |-> !launch); // R3
endmodule

// File: rtl/msix_vector_unit.sv
module msix_vector_unit
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 12,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int IW = VW + 1,
  localparam int AW = VW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regSel,
  input  logic [AW-1:0] regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic          ctlWrEn,
  input  logic          ctlEnableIn,
  input  logic          ctlMaskAllIn,
  input  logic          useWrEn,
  input  logic          useSet,
  input  logic [IW-1:0] useVec,
  input  logic          reqValid,
  input  logic [IW-1:0] reqVec,
  output logic          msgValid,
  input  logic          msgReady,
  output logic [63:0]   msgAddr,
  output logic [31:0]   msgData,
  output logic [VW-1:0] msgVec
);
  msix_strobe_t       strobe;
  logic [NUM_VEC-1:0] pendBits, vecMask;

  msix_vec_ctrl #(.NUM_VEC(NUM_VEC), .VW(VW), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlEnableIn(ctlEnableIn),
    .ctlMaskAllIn(ctlMaskAllIn), .useWrEn(useWrEn), .useSet(useSet),
    .useVec(useVec), .reqValid(reqValid), .reqVec(reqVec),
    .regWrEn(regWrEn), .regSel(regSel), .regRow(regAddr[AW-1:2]),
    .msgReady(msgReady), .vecMask(vecMask), .strobe(strobe),
    .pendBits(pendBits), .msgValid(msgValid)
  );

  msix_vec_table #(.NUM_VEC(NUM_VEC), .VW(VW), .AW(AW)) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .regAddr(regAddr), .regWdata(regWdata), .pendBits(pendBits),
    .vecMask(vecMask), .regRdata(regRdata), .msgAddr(msgAddr),
    .msgData(msgData), .msgVec(msgVec)
  );

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData)
      && $stable(msgVec)); // R10
endmodule

// File: tb/tb_msix_vector_unit.sv
module tb_msix_vector_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 12;
  localparam int VW = 4;
  localparam int IW = 5;
  localparam int AW = 6;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regSel = 0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic ctlWrEn = 0, ctlEnableIn = 0, ctlMaskAllIn = 0;
  logic useWrEn = 0, useSet = 0;
  logic [IW-1:0] useVec = '0, reqVec = '0;
  logic reqValid = 0, msgValid, msgReady = 0;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic [VW-1:0] msgVec;

  int nChecks = 0, nFails = 0, cycles = 0;
  int got[$];

  // reference state
  bit mEn, mMa, mOV;
  bit mMask[N], mPend[N], mQ[N], mUse[N];
  logic [31:0] mLo[N], mHi[N], mDat[N], mOData;
  logic [63:0] mOAddr;
  int mOVec;

  msix_vector_unit #(.NUM_VEC(N)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] modelRead(bit sel, int a);
    logic [31:0] r = '0;
    if (sel) begin
      for (int b = 0; b < 32; b++)
        if (a * 32 + b < N) r[b] = mPend[a * 32 + b];
    end else if (a / 4 < N) begin
      case (a % 4)
        0: r = mLo[a/4];
        1: r = mHi[a/4];
        2: r = mDat[a/4];
        default: r = {31'b0, mMask[a/4]};
      endcase
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    bit fm, m, hit, clr, sent, carry, doLaunch;
    bit nP[N], nQ[N];
    int pk;
    if (rstN && msgValid && msgReady) got.push_back(int'(msgVec));
    cycles++;
    if (cycles > 20000) begin
      check(0, "watchdog", 64'(cycles), 64'd20000);
      finishRun();
    end
    if (!rstN) begin
      mEn = 0; mMa = 0; mOV = 0; mOVec = 0; mOAddr = '0; mOData = '0;
      for (int v = 0; v < N; v++) begin
        mMask[v] = 1; mPend[v] = 0; mQ[v] = 0; mUse[v] = 0;
        mLo[v] = '0; mHi[v] = '0; mDat[v] = '0;
      end
    end else begin
      fm = !mEn || mMa;
      pk = -1;
      for (int v = 0; v < N; v++)
        if (pk < 0 && mQ[v] && !(fm || mMask[v])) pk = v;
      doLaunch = (pk >= 0) && (!mOV || msgReady);
      for (int v = 0; v < N; v++) begin
        m = fm || mMask[v];
        hit = reqValid && int'(reqVec) == v && mUse[v];
        clr = useWrEn && !useSet && int'(useVec) == v;
        sent = doLaunch && pk == v;
        carry = mPend[v] || hit || (mQ[v] && !sent);
        nP[v] = m && carry && !clr;
        nQ[v] = !m && carry && !clr;
      end
      if (doLaunch) begin
        mOV = 1; mOVec = pk; mOAddr = {mHi[pk], mLo[pk]}; mOData = mDat[pk];
      end else if (msgReady) mOV = 0;
      for (int v = 0; v < N; v++) begin mPend[v] = nP[v]; mQ[v] = nQ[v]; end
      if (useWrEn && int'(useVec) < N) mUse[useVec] = useSet;
      if (ctlWrEn) begin mEn = ctlEnableIn; mMa = ctlMaskAllIn; end
      if (regWrEn && !regSel && int'(regAddr) / 4 < N)
        case (int'(regAddr) % 4)
          0: mLo[regAddr/4] = regWdata;
          1: mHi[regAddr/4] = regWdata;
          2: mDat[regAddr/4] = regWdata;
          default: mMask[regAddr/4] = regWdata[0];
        endcase
    end
    #2;
    if (rstN) begin
      check(msgValid == mOV, "R5 msgValid", 64'(msgValid), 64'(mOV));
      if (mOV) begin
        check(int'(msgVec) == mOVec, "R9 msgVec", 64'(msgVec), 64'(mOVec));
        check(msgAddr == mOAddr, "R10 msgAddr", msgAddr, mOAddr);
        check(msgData == mOData, "R10 msgData", 64'(msgData), 64'(mOData));
      end
      check(regRdata == modelRead(regSel, int'(regAddr)), "R7 regRdata",
            64'(regRdata), 64'(modelRead(regSel, int'(regAddr))));
    end
  end

  task automatic wrReg(bit sel, int a, logic [31:0] d);
    regSel = sel; regAddr = AW'(a); regWdata = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rdReg(bit sel, int a, logic [31:0] exp, string tag);
    regSel = sel; regAddr = AW'(a); #1;
    check(regRdata == exp, tag, 64'(regRdata), 64'(exp));
  endtask

  task automatic setCtl(bit en, bit ma);
    ctlEnableIn = en; ctlMaskAllIn = ma; ctlWrEn = 1;
    @(negedge clk); ctlWrEn = 0;
  endtask

  task automatic setUse(int v, bit s);
    useVec = IW'(v); useSet = s; useWrEn = 1;
    @(negedge clk); useWrEn = 0;
  endtask

  task automatic request(int v);
    reqVec = IW'(v); reqValid = 1;
    @(negedge clk); reqValid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3); rstN = 1; @(negedge clk);
    // R1 reset state
    rdReg(0, 3, 32'd1, "R1 ctrl word masked");
    rdReg(0, 4*7+0, 32'd0, "R1 address zero");
    rdReg(1, 0, 32'd0, "R1 pending zero");
    // R2 table layout
    for (int v = 0; v < 4; v++) begin
      wrReg(0, 4*v+0, 32'h1000_0000 + 32'(v*16));
      wrReg(0, 4*v+1, 32'h0000_00A5);
      wrReg(0, 4*v+2, 32'h0000_D000 + 32'(v));
    end
    rdReg(0, 4*2+2, 32'h0000_D002, "R2 data word");
    rdReg(0, 4*3+1, 32'h0000_00A5, "R2 high address");
    wrReg(0, 4*5+3, 32'hFFFF_FFFF);
    rdReg(0, 4*5+3, 32'd1, "R2 ctrl upper bits zero");
    for (int v = 0; v < 4; v++) setUse(v, 1);
    setUse(11, 1);
    // R4 request while disabled
    request(1); idle(3);
    rdReg(1, 0, 32'h0000_0002, "R4 pending bit 1");
    check(got.size() == 0, "R4 no message", 64'(got.size()), 0);
    // R7 pending region ignores writes
    wrReg(1, 0, 32'h0); idle(1);
    rdReg(1, 0, 32'h0000_0002, "R7 write ignored");
    // R3 mask-all keeps vectors masked
    setCtl(1, 1);
    for (int v = 0; v < 4; v++) wrReg(0, 4*v+3, 32'd0);
    request(2); idle(3);
    rdReg(1, 0, 32'h0000_0006, "R3 mask-all holds pending");
    check(got.size() == 0, "R3 no message", 64'(got.size()), 0);
    // R6 ignored requests
    request(5); request(20); idle(3);
    rdReg(1, 0, 32'h0000_0006, "R6 ignored requests");
    // R8 R9 R10 release with stalled sink
    msgReady = 0;
    setCtl(1, 0); idle(6);
    check(msgValid == 1, "R10 held while stalled", 64'(msgValid), 1);
    msgReady = 1; idle(5);
    check(got.size() == 2, "R9 two messages", 64'(got.size()), 2);
    if (got.size() == 2) begin
      check(got[0] == 1, "R9 first vector", 64'(got[0]), 1);
      check(got[1] == 2, "R9 second vector", 64'(got[1]), 2);
    end
    rdReg(1, 0, 32'h0, "R8 pending cleared");
    // R5 direct delivery
    request(0); idle(4);
    check(got.size() == 3 && got[got.size()-1] == 0, "R5 vector 0 sent",
          64'(got[got.size()-1]), 0);
    // R3 disabled function masks an unmasked entry, R8 release on enable
    setCtl(0, 0);
    request(0); idle(3);
    rdReg(1, 0, 32'h0000_0001, "R3 disable masks");
    setCtl(1, 0); idle(5);
    check(got.size() == 4, "R8 release on enable", 64'(got.size()), 4);
    // R11 unuse clears pending
    wrReg(0, 4*3+3, 32'd1);
    request(3); idle(3);
    rdReg(1, 0, 32'h0000_0008, "R11 pending set");
    setUse(3, 0); idle(2);
    rdReg(1, 0, 32'h0, "R11 pending cleared");
    // R7 bit position for vector 11
    request(11); idle(3);
    rdReg(1, 0, 32'h0000_0800, "R7 vector 11 bit");
    rdReg(1, 1, 32'h0, "R7 upper word");
    idle(4);
    finishRun();
  end
endmodule